// File: doc/BRIEF.md
# Width-Adaptive CRC Input Queue

This block is the input queue that sits in front of a CRC engine. Software loads data words through a 32-bit data port that has four byte enables. Bytes 0 and 1 form the low half of the port and bytes 2 and 3 form the high half. Bytes that arrive early are held in a staging register. A word enters the queue only when the byte lane that holds the most significant configured data bit is written. That word is the staged bytes merged with the bytes written in the same cycle, with every bit above the configured width forced to zero.

The width field sets the data width, which is the field value plus one. The same field sets the queue depth: wider words give a shallower queue. The engine side takes words with a pop request. Each pop moves the oldest word into a holding buffer that the engine reads.

The block shows a word count, full and empty flags, and a sticky overflow flag. Pulling the enable low flushes the whole queue.

Top module: `crc_infifo`

## Requirements
- R1: The depth is 16 words when the width field is 0 to 7, 8 words when it is 8 to 15, and 4 words when it is 16 to 31.
- R2: The data width is the width field plus one. A committed word keeps bits 0 up to the field value and reads as zero in every bit above it.
- R3: A commit happens when byte enable lane (width field / 8) is set while the enable is high. The count rises by one at the next clock edge, so a read in the commit cycle still shows the old count.
- R4: Byte lanes written without the commit lane are held in staging. The committed word is the staging contents with the commit-cycle lanes overlaid, and staging is cleared after each commit.
- R5: A pop while the count is non-zero loads the oldest word into the holding buffer at the next edge and lowers the count by one. A pop on an empty queue changes nothing. A pop and an accepted commit in the same cycle leave the count unchanged.
- R6: Full is high exactly when the count equals the depth for the current width field. Empty is high exactly when the count is zero.
- R7: While the enable is low, the count, staging, holding buffer and overflow flag are cleared and writes and pops have no effect. The same state holds after reset.
- R8: A commit attempted while full is dropped and sets a sticky overflow flag. Only a low enable or reset clears that flag.
- R9: Words leave the queue in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low flushes the queue |
| width_cfg | input | 5 | Data width minus one |
| wr_data | input | 32 | Write data, four byte lanes |
| wr_be | input | 4 | Byte enables, lane n covers bits 8n+7..8n |
| pop | input | 1 | Engine request to take the oldest word |
| hold_word | output | 32 | Holding buffer loaded by a pop |
| count | output | 5 | Number of words queued |
| full | output | 1 | Count equals the current depth |
| empty | output | 1 | Count is zero |
| overflow | output | 1 | Sticky flag for a dropped commit |

## Verification
Wrong internal state shows up at the ports. A bad pointer or storage fault appears in hold_word on the first pop that reaches the affected slot, and in a random stream that is within a few words. A wrong count or depth decode shows up on count, full or empty at the edge right after the commit or pop that caused it. A staging or masking fault shows up only when that word reaches the holding buffer. The checks therefore pop every queued word and compare it against an independently merged and masked model word.

// File: rtl/crc_infifo_pkg.sv
package crc_infifo_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int CFG_W     = $clog2(DATA_W);
  localparam int MAX_DEPTH = 16;
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1);
  localparam int PTR_W     = $clog2(MAX_DEPTH);

  // Depth for a width field: 16, 8 or 4 entries.
  function automatic logic [CNT_W-1:0] depth_for(input logic [CFG_W-1:0] wcfg);
    if (wcfg > CFG_W'(15))     return CNT_W'(MAX_DEPTH / 4);
    else if (wcfg > CFG_W'(7)) return CNT_W'(MAX_DEPTH / 2);
    else                       return CNT_W'(MAX_DEPTH);
  endfunction

  // Byte lane holding the most significant configured bit.
  function automatic logic [LANE_W-1:0] top_lane(input logic [CFG_W-1:0] wcfg);
    return LANE_W'(wcfg >> 3);
  endfunction

  // Keeps bits 0..wcfg.
  function automatic logic [DATA_W-1:0] width_mask(input logic [CFG_W-1:0] wcfg);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(wcfg));
    return m;
  endfunction
endpackage

// File: rtl/crc_infifo_stage.sv
module crc_infifo_stage
  import crc_infifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CFG_W-1:0]  width_cfg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  output logic              commit,
  output logic [DATA_W-1:0] commit_word
);
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] merged;
  logic [LANE_W-1:0] lane_top;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign merged[ln*8 +: 8] = wr_be[ln] ? wr_data[ln*8 +: 8] : stage_q[ln*8 +: 8];
  end

  assign lane_top    = top_lane(width_cfg);
  assign commit      = enable & wr_be[lane_top];
  assign commit_word = merged & width_mask(width_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stage_q <= '0;
    else if (!enable)    stage_q <= '0;
    else if (commit)     stage_q <= '0;
    else if (|wr_be)     stage_q <= merged;
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_be == '0) |=> $stable(stage_q)); // R4
  AST_STAGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> stage_q == '0); // R7
endmodule

// File: rtl/crc_infifo_ctrl.sv
module crc_infifo_ctrl
  import crc_infifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] width_cfg,
  input  logic             commit,
  input  logic             pop,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] depth_cur;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             ovf_q;
  logic             drop;

  assign depth_cur = depth_for(width_cfg);
  assign full      = (count_q == depth_cur);
  assign empty     = (count_q == '0);
  assign push_ok   = commit & ~full;
  assign drop      = commit & full;
  assign pop_ok    = enable & pop & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0; wr_q <= '0; rd_q <= '0; ovf_q <= 1'b0;
    end else if (!enable) begin
      count_q <= '0; wr_q <= '0; rd_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
      else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign wr_ptr   = wr_q;
  assign rd_ptr   = rd_q;
  assign count    = count_q;
  assign overflow = ovf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_DEPTH)); // R1
  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> count_q == $past(count_q) + 1'b1); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> count_q == $past(count_q) - 1'b1); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R6
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count_q == '0 && !ovf_q)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && enable) |=> ovf_q); // R8
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop_ok) |=> $stable(count_q)); // R8
endmodule

// File: rtl/crc_infifo_store.sv
module crc_infifo_store
  import crc_infifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [DATA_W-1:0] push_word,
  output logic [DATA_W-1:0] hold_word
);
  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (!enable) hold_q <= '0;
    else if (pop_ok)  hold_q <= mem[rd_ptr];
  end

  assign hold_word = hold_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pop_ok) |=> $stable(hold_q)); // R5
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> hold_q == '0); // R7
endmodule

// File: rtl/crc_infifo.sv
module crc_infifo
  import crc_infifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CFG_W-1:0]  width_cfg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic              pop,
  output logic [DATA_W-1:0] hold_word,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  logic              commit;
  logic [DATA_W-1:0] commit_word;
  logic              push_ok, pop_ok;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  crc_infifo_stage u_stage (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_cfg(width_cfg),
    .wr_data(wr_data), .wr_be(wr_be), .commit(commit), .commit_word(commit_word)
  );

  crc_infifo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_cfg(width_cfg),
    .commit(commit), .pop(pop), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .full(full),
    .empty(empty), .overflow(overflow)
  );

  crc_infifo_store u_store (
    .clk(clk), .rst_n(rst_n), .enable(enable), .push_ok(push_ok),
    .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .push_word(commit_word), .hold_word(hold_word)
  );

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !commit) |=> empty); // R5
endmodule

// File: tb/crc_infifo_tb_top.sv
module crc_infifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  width_cfg = 5'd31;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        pop = 1'b0;
  logic [31:0] hold_word;
  logic [4:0]  count;
  logic        full, empty, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] mq[$];
  logic [31:0] m_stage = '0;
  logic [31:0] m_hold = '0;
  bit          m_ovf = 0;

  always #2.5 clk = ~clk;

  crc_infifo dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_cfg(width_cfg),
    .wr_data(wr_data), .wr_be(wr_be), .pop(pop), .hold_word(hold_word),
    .count(count), .full(full), .empty(empty), .overflow(overflow)
  );

  function automatic int b_depth(input int w);
    case (w / 8)
      0:       return 16;
      1:       return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] b_mask(input int w);
    if (w >= 31) return 32'hFFFF_FFFF;
    return (32'h1 << (w + 1)) - 32'h1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 count", 32'(count), 32'(mq.size()));
    chk("R6 full", 32'(full), 32'(mq.size() == b_depth(width_cfg)));
    chk("R6 empty", 32'(empty), 32'(mq.size() == 0));
    chk("R8 overflow", 32'(overflow), 32'(m_ovf));
    chk("R5 R9 hold", hold_word, m_hold);
  endtask

  task automatic cyc(input bit en_i, input logic [4:0] w_i, input logic [31:0] d_i,
                     input logic [3:0] be_i, input bit p_i);
    logic [31:0] merged;
    bit commit, push_ok, pop_ok;
    int depth;
    @(negedge clk);
    enable = en_i; width_cfg = w_i; wr_data = d_i; wr_be = be_i; pop = p_i;
    #1;
    chk("R3 old count before edge", 32'(count), 32'(mq.size()));
    @(posedge clk);
    #1;
    if (!en_i) begin
      mq.delete(); m_stage = '0; m_hold = '0; m_ovf = 0;
    end else begin
      for (int b = 0; b < 4; b++)
        merged[b*8 +: 8] = be_i[b] ? d_i[b*8 +: 8] : m_stage[b*8 +: 8];
      depth   = b_depth(w_i);
      commit  = be_i[w_i / 8];
      push_ok = commit && (mq.size() < depth);
      pop_ok  = p_i && (mq.size() > 0);
      if (pop_ok) m_hold = mq.pop_front();
      if (push_ok) mq.push_back(merged & b_mask(w_i));
      if (commit && !push_ok) m_ovf = 1;
      if (commit) m_stage = '0;
      else if (be_i != 0) m_stage = merged;
    end
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [4:0] w;
    logic [4:0] widths [6];
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    chk("R7 reset count", 32'(count), 0);
    chk("R7 reset empty", 32'(empty), 1);
    chk("R7 reset full", 32'(full), 0);
    chk("R7 reset overflow", 32'(overflow), 0);
    chk("R7 reset hold", hold_word, 0);
    rst_n = 1'b1;

    // R1 R8 R9: fill each width to its depth, overflow once, drain
    widths = '{5'd31, 5'd16, 5'd15, 5'd8, 5'd7, 5'd0};
    foreach (widths[k]) begin
      w = widths[k];
      cyc(0, w, '0, '0, 0);
      for (int i = 0; i < b_depth(w); i++)
        cyc(1, w, $urandom(), 4'b1111, 0);
      chk("R1 depth reached", 32'(count), 32'(b_depth(w)));
      chk("R1 full at depth", 32'(full), 1);
      cyc(1, w, 32'hDEAD_BEEF, 4'b1111, 0);
      chk("R8 overflow set on dropped commit", 32'(overflow), 1);
      chk("R8 count unchanged on drop", 32'(count), 32'(b_depth(w)));
      for (int i = 0; i < b_depth(w); i++) cyc(1, w, '0, '0, 1);
      cyc(1, w, '0, '0, 1); // pop on empty
      chk("R8 overflow sticky", 32'(overflow), 1);
    end

    // R4: staged lanes for a 32-bit word
    cyc(0, 5'd31, '0, '0, 0);
    cyc(1, 5'd31, 32'h0000_00A1, 4'b0001, 0);
    cyc(1, 5'd31, 32'h0000_B200, 4'b0010, 0);
    chk("R4 no commit from low lanes", 32'(count), 0);
    cyc(1, 5'd31, 32'h00C3_0000, 4'b0100, 0);
    cyc(1, 5'd31, 32'hD400_0000, 4'b1000, 0);
    cyc(1, 5'd31, '0, '0, 1);
    chk("R4 merged word", hold_word, 32'hD4C3_B2A1);

    // R2: width 5 bits keeps only bits 4..0
    cyc(1, 5'd4, 32'hFFFF_FFFF, 4'b0001, 0);
    cyc(1, 5'd4, '0, '0, 1);
    chk("R2 masked narrow word", hold_word, 32'h0000_001F);
    // R2: width 12 commits on lane 1
    cyc(1, 5'd11, 32'hFFFF_FF77, 4'b0001, 0);
    chk("R3 lane 0 is not the commit lane at width 12", 32'(count), 0);
    cyc(1, 5'd11, 32'hFFFF_EEFF, 4'b0010, 0);
    cyc(1, 5'd11, '0, '0, 1);
    chk("R2 masked 12-bit word", hold_word, 32'h0000_0E77);

    // R5: pop and commit together keeps count
    cyc(1, 5'd31, 32'h1111_1111, 4'b1111, 0);
    cyc(1, 5'd31, 32'h2222_2222, 4'b1111, 1);
    chk("R5 simultaneous pop and push", 32'(count), 1);

    // R7: writes while disabled ignored
    cyc(0, 5'd31, 32'h3333_3333, 4'b1111, 1);
    cyc(0, 5'd31, 32'h4444_4444, 4'b1111, 0);
    chk("R7 disabled write ignored", 32'(count), 0);
    chk("R7 disabled clears overflow", 32'(overflow), 0);

    // random phase
    w = 5'd31;
    for (int n = 0; n < 5000; n++) begin
      bit en;
      logic [3:0] be;
      en = ($urandom_range(99) >= 2);
      if (mq.size() == 0 && m_stage == 0 && $urandom_range(99) < 8)
        w = 5'($urandom_range(31));
      be = ($urandom_range(99) < 30) ? 4'b0000 : 4'($urandom_range(15));
      cyc(en, w, $urandom(), be, ($urandom_range(99) < 40));
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule